// File: doc/BRIEF.md
# Program Counter with Privilege Bit

This block holds the program counter of a word-addressed processor. It works out the next value of that counter on every cycle. The most significant bit of the counter is a privilege flag: when it is set, the code runs in supervisor mode. The remaining bits are the word address of the instruction.

The next value comes from one of these sources:

- the sequential increment,
- a relative branch,
- a register-indirect jump,
- the illegal-opcode trap vector,
- the interrupt vector,
- the reset vector.

Sequential steps and branches keep the privilege flag as it is. A jump can clear the flag but never set it. Only trap and interrupt vectoring set it.

The block has three outputs. The first is the current counter. The second is the incremented counter, which the register file saves as the link or return address. The third is the word address for instruction memory, with the privilege flag removed. With the flag removed, a privileged fetch and a user fetch of the same address return the same word. Instruction decode drives the select code, the enable, the branch offset and the jump target. Decode and the register file lie outside this block.

Top module: `pc_sup_unit`

## Requirements
- R1: After a rising clock edge with `rst` high, `pcOut` is 0x00000000, `pcPlusOne` is 0x00000001 and `imemAddr` is 0.
- R2: `imemAddr` always equals bits 30..0 of `pcOut`, so bit 31 (the privilege flag) has no effect on the fetch address.
- R3: `pcPlusOne` is bit 31 of `pcOut` joined with (bits 30..0 of `pcOut` + 1) mod 2^31. With `pcEnable` high, `irqReq` low and `pcSel` = 0 (sequential), the next `pcOut` takes this value.
- R4: With `pcSel` = 1 (branch), `pcEnable` high and `irqReq` low, bits 30..0 of the next counter are (current low bits + 1 + sign-extended 16-bit `branchOffset`) mod 2^31. This reaches from -32768 to +32767 words relative to PC+1.
- R5: With `pcSel` = 2 (jump), `pcEnable` high and `irqReq` low, the next counter takes bits 30..0 from `jumpTarget`. Its bit 31 is the old bit 31 AND `jumpTarget` bit 31.
- R6: With `pcSel` = 3 (trap), `pcEnable` high and `irqReq` low, the next counter is 0x80000001.
- R7: With `pcEnable` and `irqReq` both high, the next counter is 0x80000002, whatever the value of `pcSel`, including the trap code.
- R8: With `pcEnable` low and `rst` low, the counter holds its value, and `pcSel`, `irqReq`, `branchOffset` and `jumpTarget` have no effect.
- R9: Sequential and branch updates never change bit 31. This holds when the low bits wrap: 0x7FFFFFFF steps to 0x00000000, and 0xFFFFFFFF steps to 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, loads address 0 |
| pcEnable | input | 1 | Allows the counter to update; low while halted |
| pcSel | input | 2 | Next-address source: 0 sequential, 1 branch, 2 jump, 3 trap |
| irqReq | input | 1 | Interrupt request; takes priority over every select code |
| branchOffset | input | 16 | Signed word offset relative to PC+1 |
| jumpTarget | input | 32 | Jump destination read from a register |
| pcOut | output | 32 | Current counter, privilege flag in bit 31 |
| pcPlusOne | output | 32 | Incremented counter, privilege flag kept, used as link value |
| imemAddr | output | 31 | Word address to instruction memory, privilege flag removed |

## Verification
The assertions assume that `pcEnable`, `irqReq` and `pcSel` are never unknown once reset has ended. They also assume that reset is held high across the first rising edge. The stimulus meets both conditions because it drives every input to a known value at time zero and then changes them only on the falling edge. The random phase covers the following:

- it asserts reset now and then in mid-run, so the assertions are checked again after a reset;
- it mixes halted cycles, interrupts and all four select codes;
- it mixes jump targets with and without bit 31 set, so that jumps are taken from both privilege states.

// File: rtl/pc_sup_pkg.sv
package pc_sup_pkg;

  // Next-address source codes driven by instruction decode
  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_JUMP   = 2'd2,
    SEL_TRAP   = 2'd3
  } pcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic takeBranch;
    logic takeJump;
    logic takeTrap;
    logic takeIrq;
  } pcStrobes_t;

endpackage

// File: rtl/pc_sup_ctrl.sv
module pc_sup_ctrl
  import pc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pcEnable,
  input  logic [1:0] pcSel,
  input  logic       irqReq,
  output pcStrobes_t strobe
);

  pcSel_e selCode;
  logic   normalPath;

  always_comb begin
    selCode           = pcSel_e'(pcSel);
    normalPath        = pcEnable & ~irqReq;
    strobe.load       = pcEnable;
    strobe.takeIrq    = pcEnable & irqReq;
    strobe.takeTrap   = normalPath & (selCode == SEL_TRAP);
    strobe.takeJump   = normalPath & (selCode == SEL_JUMP);
    strobe.takeBranch = normalPath & (selCode == SEL_BRANCH);
  end

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.takeIrq, strobe.takeTrap, strobe.takeJump, strobe.takeBranch}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pcEnable |-> !(strobe.takeIrq | strobe.takeTrap | strobe.takeJump | strobe.takeBranch));

endmodule

// File: rtl/pc_sup_datapath.sv
module pc_sup_datapath
  import pc_sup_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int OFF_W = 16,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] TRAP_VEC = {1'b1, {(PC_W-2){1'b0}}, 1'b1},
  parameter logic [PC_W-1:0] IRQ_VEC = {1'b1, {(PC_W-3){1'b0}}, 2'b10}
) (
  input  logic             clk,
  input  logic             rst,
  input  pcStrobes_t       strobe,
  input  logic [OFF_W-1:0] branchOffset,
  input  logic [PC_W-1:0]  jumpTarget,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  pcPlusOne,
  output logic [PC_W-2:0]  imemAddr
);

  localparam int LOW_W = PC_W - 1;
  localparam int EXT_W = LOW_W - OFF_W;

  logic [PC_W-1:0]  pcReg;
  logic [PC_W-1:0]  nextPc;
  logic             supBit;
  logic [LOW_W-1:0] lowAddr;
  logic [LOW_W-1:0] incLow;
  logic [LOW_W-1:0] offExt;
  logic [LOW_W-1:0] branchLow;
  logic             jumpSup;

  always_comb begin
    supBit    = pcReg[PC_W-1];
    lowAddr   = pcReg[LOW_W-1:0];
    incLow    = lowAddr + {{(LOW_W-1){1'b0}}, 1'b1};
    offExt    = {{EXT_W{branchOffset[OFF_W-1]}}, branchOffset};
    branchLow = incLow + offExt;
    jumpSup   = supBit & jumpTarget[PC_W-1];
  end

  always_comb begin
    if (strobe.takeIrq)         nextPc = IRQ_VEC;
    else if (strobe.takeTrap)   nextPc = TRAP_VEC;
    else if (strobe.takeJump)   nextPc = {jumpSup, jumpTarget[LOW_W-1:0]};
    else if (strobe.takeBranch) nextPc = {supBit, branchLow};
    else                        nextPc = {supBit, incLow};
  end

  always_ff @(posedge clk) begin
    if (rst)              pcReg <= RESET_VEC;
    else if (strobe.load) pcReg <= nextPc;
  end

  assign pcOut     = pcReg;
  assign pcPlusOne = {supBit, incLow};
  assign imemAddr  = lowAddr;

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(pcReg));

  // R9
  sup_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.takeIrq && !strobe.takeTrap && !strobe.takeJump)
      |=> pcReg[PC_W-1] == $past(supBit));

  // R5
  jump_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.takeJump && !supBit) |=> !pcReg[PC_W-1]);

  // R6
  trap_vector_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.takeTrap |=> pcReg == TRAP_VEC);

  // R7
  irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.takeIrq |=> pcReg == IRQ_VEC);

endmodule

// File: rtl/pc_sup_unit.sv
module pc_sup_unit
  import pc_sup_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pcEnable,
  input  logic [1:0]       pcSel,
  input  logic             irqReq,
  input  logic [OFF_W-1:0] branchOffset,
  input  logic [PC_W-1:0]  jumpTarget,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  pcPlusOne,
  output logic [PC_W-2:0]  imemAddr
);

  pcStrobes_t strobe;

  pc_sup_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pcEnable (pcEnable),
    .pcSel    (pcSel),
    .irqReq   (irqReq),
    .strobe   (strobe)
  );

  pc_sup_datapath #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .branchOffset (branchOffset),
    .jumpTarget   (jumpTarget),
    .pcOut        (pcOut),
    .pcPlusOne    (pcPlusOne),
    .imemAddr     (imemAddr)
  );

endmodule

// File: tb/pc_sup_unit_test.sv
module pc_sup_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pcEnable = 1'b1;
  logic [1:0]  pcSel = 2'd0;
  logic        irqReq = 1'b0;
  logic [15:0] branchOffset = 16'd0;
  logic [31:0] jumpTarget = 32'd0;
  logic [31:0] pcOut;
  logic [31:0] pcPlusOne;
  logic [30:0] imemAddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] refPc = 32'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sup_unit uut (
    .clk(clk), .rst(rst), .pcEnable(pcEnable), .pcSel(pcSel), .irqReq(irqReq),
    .branchOffset(branchOffset), .jumpTarget(jumpTarget),
    .pcOut(pcOut), .pcPlusOne(pcPlusOne), .imemAddr(imemAddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Next counter from the requirement text
  function automatic logic [31:0] refNext(input logic [31:0] cur, input logic r,
      input logic en, input logic [1:0] sel, input logic irq,
      input logic [15:0] off, input logic [31:0] ra);
    logic [30:0] low;
    logic [30:0] ext;
    if (r) return 32'h0000_0000;
    if (!en) return cur;
    if (irq) return 32'h8000_0002;
    ext = {{15{off[15]}}, off};
    case (sel)
      2'd0: begin low = cur[30:0] + 31'd1; return {cur[31], low}; end
      2'd1: begin low = cur[30:0] + 31'd1 + ext; return {cur[31], low}; end
      2'd2: return {cur[31] & ra[31], ra[30:0]};
      default: return 32'h8000_0001;
    endcase
  endfunction

  task automatic step(input logic r, input logic en, input logic [1:0] sel,
      input logic irq, input logic [15:0] off, input logic [31:0] ra);
    string tag;
    logic [31:0] exp;
    logic [30:0] incLow;
    rst = r; pcEnable = en; pcSel = sel; irqReq = irq;
    branchOffset = off; jumpTarget = ra;
    exp = refNext(refPc, r, en, sel, irq, off, ra);
    if (r) tag = "R1";
    else if (!en) tag = "R8";
    else if (irq) tag = "R7";
    else if (sel == 2'd0) tag = "R3";
    else if (sel == 2'd1) tag = "R4";
    else if (sel == 2'd2) tag = "R5";
    else tag = "R6";
    @(negedge clk);
    if (!r && en && !irq && sel[1] == 1'b0)
      check("R9 sup", {31'd0, pcOut[31]}, {31'd0, refPc[31]});
    refPc = exp;
    check(tag, pcOut, refPc);
    check("R2 imem", {1'b0, imemAddr}, {1'b0, refPc[30:0]});
    incLow = refPc[30:0] + 31'd1;
    check("R3 link", pcPlusOne, {refPc[31], incLow});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step(1, 1, 0, 0, 0, 0);
    // R3 sequential steps
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    // R4 branch forward, backward, extreme offsets
    step(0, 1, 1, 0, 16'd100, 0);
    step(0, 1, 1, 0, 16'hFFF0, 0);
    step(0, 1, 1, 0, 16'h7FFF, 0);
    step(0, 1, 1, 0, 16'h8000, 0);
    // R5 user jump cannot raise privilege
    step(0, 1, 2, 0, 0, 32'h8000_1234);
    // R8 halted: inputs ignored, including irq and trap
    step(0, 0, 3, 1, 16'h1234, 32'hFFFF_FFFF);
    step(0, 0, 2, 0, 16'h4321, 32'h0000_0055);
    // R6 trap sets privilege
    step(0, 1, 3, 0, 0, 0);
    // R5 privileged jump keeping and then clearing the flag
    step(0, 1, 2, 0, 0, 32'h8000_001A);
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 2, 0, 0, 32'h0000_001A);
    // R7 irq beats trap and other codes
    step(0, 1, 3, 1, 0, 0);
    step(0, 1, 0, 1, 0, 0);
    // R9 wrap with privilege set: 0xFFFFFFFF -> 0x80000000
    step(0, 1, 2, 0, 0, 32'hFFFF_FFFF);
    step(0, 1, 0, 0, 0, 0);
    // R9 wrap in user mode: 0x7FFFFFFF -> 0
    step(0, 1, 2, 0, 0, 32'h7FFF_FFFF);
    step(0, 1, 0, 0, 0, 0);
    // R9 branch wrap keeps privilege
    step(0, 1, 3, 0, 0, 0);
    step(0, 1, 1, 0, 16'h8000, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic r;
      logic en;
      logic irq;
      r   = ($urandom_range(99) == 0);
      en  = ($urandom_range(9) != 0);
      irq = ($urandom_range(9) == 0);
      step(r, en, 2'($urandom_range(3)), irq, 16'($urandom), 32'($urandom));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule